// File: doc/BRIEF.md
# SECDED Hamming Codec

This block protects a small data word on its way into and out of memory. The encoder half turns a data word into a codeword: Hamming check bits interleaved with the data, plus one overall parity bit. The decoder half takes a codeword back from storage and recomputes every check bit. It corrects any single flipped bit and reports a flip of two bits as uncorrectable. It also recognises the case where only the overall parity bit was hit. Both halves are purely combinational and independent of each other, so a controller can place a register stage wherever its timing needs one.

The data width is a parameter. The number of check bits and the codeword width follow from it. With the default of 4 data bits, the codeword is 8 bits wide. Position `p` (1 to 7) of the Hamming word sits at codeword bit `p-1`, and the overall parity bit is bit 7. Check bit `i` sits at position `2^i`. Data bits fill the remaining positions in ascending order. Because of this layout, a nonzero syndrome is directly the position of the bit that flipped.

Top module: `secded_codec`

## Requirements
- R1: With the default width, `codeOut[7:0]` holds, from bit 0 to bit 7: c1, c2, d1, c3, d2, d3, d4, c4, where `dataIn[3:0]` = {d4,d3,d2,d1}.
- R2: The check bits are c1 = d1^d2^d4, c2 = d1^d3^d4 and c3 = d2^d3^d4. For data 4'b0110 the codeword is 8'h33.
- R3: The overall parity bit (the top codeword bit) equals the XOR of all other codeword bits, so every codeword has even parity.
- R4: A received codeword with no flipped bit raises only `flagClean`, gives `syndrome` = 0 and returns the original data.
- R5: A single flipped bit at Hamming position p (codeword bit p-1) raises only `flagCorrected`, gives `syndrome` = p and returns the original data. In the default codec, a flip of d2 in the codeword of 4'b0110 gives syndrome 5, and a flip of c2 gives syndrome 2.
- R6: A flip of only the overall parity bit raises only `flagCorrected`, with `syndrome` = 0, and returns the original data.
- R7: Two flipped bits raise only `flagUncorr`. `syndrome` equals the XOR of the two flipped positions, with the overall parity bit counting as position 0. `dataOut` is the data read from the received codeword without any correction.
- R8: Exactly one of `flagClean`, `flagCorrected` and `flagUncorr` is high for every input.
- R9: The rules above hold for any data width. The check bit count is the smallest c with 2^c >= DATA_W + c + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | DATA_W | Data word to encode |
| codeOut | output | CODE_W | Encoded codeword |
| codeIn | input | CODE_W | Codeword read back from storage |
| dataOut | output | DATA_W | Decoded (corrected where possible) data |
| syndrome | output | CHK_W | Recomputed check bits XOR stored check bits |
| flagClean | output | 1 | No error found |
| flagCorrected | output | 1 | Single error corrected (including overall parity bit) |
| flagUncorr | output | 1 | Double error detected, data passed through raw |

## Verification
The bench builds two copies of the codec. The first uses the default 4 data bits, which gives the 8-bit codeword with its fixed bit order and the worked example. The second uses 11 data bits, which gives a full 16-bit codeword with four check bits. On the wide copy, every syndrome value from 1 to 15 can be reached, and the position mapping is exercised well past the first power of two. On both copies, random data words are combined with zero, one and two distinct flipped bits. The flip cases cover the overall parity bit as well as the interleaved check bits.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // smallest number of Hamming check bits able to address dw data bits
  function automatic int chkBits(int dw);
    int c;
    c = 1;
    while ((1 << c) < dw + c + 1) c++;
    return c;
  endfunction

  function automatic bit isPow2(int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // Hamming position (1-based) of data bit k: k-th position that is not a power of two
  function automatic int dataPos(int k);
    int cnt;
    cnt = 0;
    for (int p = 1; p < 4096; p++) begin
      if (!isPow2(p)) begin
        if (cnt == k) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  typedef struct packed {
    logic fixEn;      // apply the syndrome-selected bit flip
  } ctrlT;

  typedef struct packed {
    logic clean;
    logic corrected;
    logic uncorr;
  } statusT;

endpackage

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int CHK_W = chkBits(DATA_W),
  localparam int NPOS = DATA_W + CHK_W,
  localparam int CODE_W = NPOS + 1
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CODE_W-1:0] codeOut,
  input  logic [CODE_W-1:0] codeIn,
  input  ctrlT              ctrl,
  output logic [DATA_W-1:0] dataOut,
  output logic [CHK_W-1:0]  syndrome,
  output logic              synZero,
  output logic              synValid,
  output logic              parErr
);

  // ---------------- encoder ----------------
  logic [NPOS:1] dataPlaced;
  logic [NPOS:1] encWord;
  logic [CHK_W-1:0] encChk;

  for (genvar p = 1; p <= NPOS; p++) begin : g_pow
    if (isPow2(p)) begin : g_zero
      assign dataPlaced[p] = 1'b0;
    end
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_place
    assign dataPlaced[dataPos(k)] = dataIn[k];
  end

  always_comb begin
    encChk = '0;
    for (int p = 1; p <= NPOS; p++) begin
      for (int i = 0; i < CHK_W; i++) begin
        if (p[i]) encChk[i] = encChk[i] ^ dataPlaced[p];
      end
    end
    encWord = dataPlaced;
    for (int i = 0; i < CHK_W; i++) begin
      encWord[1 << i] = encChk[i];
    end
  end

  assign codeOut = {^encWord, encWord};

  // ---------------- decoder ----------------
  logic [NPOS-1:0] recvWord;
  logic [NPOS-1:0] fixedWord;

  assign recvWord = codeIn[NPOS-1:0];

  always_comb begin
    syndrome = '0;
    for (int p = 1; p <= NPOS; p++) begin
      for (int i = 0; i < CHK_W; i++) begin
        if (p[i]) syndrome[i] = syndrome[i] ^ recvWord[p-1];
      end
    end
  end

  assign parErr   = ^codeIn;
  assign synZero  = (syndrome == '0);
  assign synValid = (int'(syndrome) <= NPOS);

  always_comb begin
    fixedWord = recvWord;
    if (ctrl.fixEn) begin
      for (int p = 1; p <= NPOS; p++) begin
        if (int'(syndrome) == p) fixedWord[p-1] = ~recvWord[p-1];
      end
    end
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_extract
    assign dataOut[k] = fixedWord[dataPos(k)-1];
  end

endmodule

// File: rtl/secded_control.sv
module secded_control
  import secded_pkg::*;
(
  input  logic   synZero,
  input  logic   synValid,
  input  logic   parErr,
  output ctrlT   ctrl,
  output statusT status
);

  // four-way decision on (syndrome zero?, overall parity mismatch?)
  always_comb begin
    ctrl   = '0;
    status = '0;
    unique case ({synZero, parErr})
      2'b10: status.clean = 1'b1;                 // nothing flipped
      2'b11: status.corrected = 1'b1;             // only the overall parity bit
      2'b01: begin                                 // odd flip count, position named
        if (synValid) begin
          ctrl.fixEn       = 1'b1;
          status.corrected = 1'b1;
        end else begin
          status.uncorr = 1'b1;                    // names no real position
        end
      end
      default: status.uncorr = 1'b1;               // even flip count, nonzero syndrome
    endcase
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int CHK_W = chkBits(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W + 1
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CODE_W-1:0] codeOut,
  input  logic [CODE_W-1:0] codeIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [CHK_W-1:0]  syndrome,
  output logic              flagClean,
  output logic              flagCorrected,
  output logic              flagUncorr
);

  ctrlT   ctrl;
  statusT status;
  logic   synZero;
  logic   synValid;
  logic   parErr;

  secded_datapath #(.DATA_W(DATA_W)) dp (
    .dataIn   (dataIn),
    .codeOut  (codeOut),
    .codeIn   (codeIn),
    .ctrl     (ctrl),
    .dataOut  (dataOut),
    .syndrome (syndrome),
    .synZero  (synZero),
    .synValid (synValid),
    .parErr   (parErr)
  );

  secded_control ctl (
    .synZero  (synZero),
    .synValid (synValid),
    .parErr   (parErr),
    .ctrl     (ctrl),
    .status   (status)
  );

  assign flagClean     = status.clean;
  assign flagCorrected = status.corrected;
  assign flagUncorr    = status.uncorr;

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
  import secded_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int CHK_W = chkBits(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W + 1
) (
  input logic [DATA_W-1:0] dataIn,
  input logic [CODE_W-1:0] codeOut,
  input logic [CODE_W-1:0] codeIn,
  input logic [DATA_W-1:0] dataOut,
  input logic [CHK_W-1:0]  syndrome,
  input logic              flagClean,
  input logic              flagCorrected,
  input logic              flagUncorr
);

  logic [DATA_W-1:0] rawData;
  for (genvar k = 0; k < DATA_W; k++) begin : g_raw
    assign rawData[k] = codeIn[dataPos(k)-1];
  end

  always_comb begin
    // R8
    flags_onehot_chk: assert ($countones({flagClean, flagCorrected, flagUncorr}) == 1);
    // R3
    code_parity_chk: assert ((^codeOut) == 1'b0);
    // R4
    if (codeIn == codeOut) begin
      loopback_clean_chk: assert (flagClean && (dataOut == dataIn));
    end
    // R4
    if (flagClean) begin
      clean_syndrome_chk: assert ((syndrome == '0) && (dataOut == rawData));
    end
    // R6
    if (flagCorrected && (syndrome == '0)) begin
      parity_only_chk: assert (dataOut == rawData);
    end
    // R7
    if (flagUncorr) begin
      uncorr_raw_chk: assert ((dataOut == rawData) && (syndrome != '0));
    end
  end

endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W)) chk (
  .dataIn        (dataIn),
  .codeOut       (codeOut),
  .codeIn        (codeIn),
  .dataOut       (dataOut),
  .syndrome      (syndrome),
  .flagClean     (flagClean),
  .flagCorrected (flagCorrected),
  .flagUncorr    (flagUncorr)
);

// File: tb/secded_codec_test.sv
module secded_codec_test;

  localparam int WIDE_W = 11;   // 4 check bits, 16-bit codeword

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;         // 250 MHz

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  logic [3:0]  nData;
  logic [7:0]  nCodeOut, nCodeIn;
  logic [3:0]  nDataOut;
  logic [2:0]  nSyn;
  logic        nClean, nCorr, nUnc;

  logic [10:0] wData;
  logic [15:0] wCodeOut, wCodeIn;
  logic [10:0] wDataOut;
  logic [3:0]  wSyn;
  logic        wClean, wCorr, wUnc;

  secded_codec uut (
    .dataIn(nData), .codeOut(nCodeOut), .codeIn(nCodeIn), .dataOut(nDataOut),
    .syndrome(nSyn), .flagClean(nClean), .flagCorrected(nCorr), .flagUncorr(nUnc)
  );

  secded_codec #(.DATA_W(WIDE_W)) wideUut (
    .dataIn(wData), .codeOut(wCodeOut), .codeIn(wCodeIn), .dataOut(wDataOut),
    .syndrome(wSyn), .flagClean(wClean), .flagCorrected(wCorr), .flagUncorr(wUnc)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // explicit equations for the 4-bit code (R1, R2, R3)
  function automatic logic [7:0] enc4(logic [3:0] d);
    logic c1, c2, c3, c4;
    c1 = d[0] ^ d[1] ^ d[3];
    c2 = d[0] ^ d[2] ^ d[3];
    c3 = d[1] ^ d[2] ^ d[3];
    c4 = c1 ^ c2 ^ d[0] ^ c3 ^ d[1] ^ d[2] ^ d[3];
    return {c4, d[3], d[2], d[1], c3, d[0], c2, c1};
  endfunction

  // generic reference: positions that are not powers of two carry data in order
  function automatic bit pw2(int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  function automatic logic [15:0] encW(logic [10:0] d);
    logic [15:0] w;
    int k;
    w = '0; k = 0;
    for (int p = 1; p <= 15; p++) if (!pw2(p)) begin w[p-1] = d[k]; k++; end
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = 1'b0;
      for (int p = 1; p <= 15; p++) if (((p >> i) & 1) == 1 && !pw2(p)) b ^= w[p-1];
      w[(1 << i) - 1] = b;
    end
    w[15] = ^w[14:0];
    return w;
  endfunction

  function automatic logic [10:0] rawW(logic [15:0] c);
    logic [10:0] d;
    int k;
    k = 0;
    for (int p = 1; p <= 15; p++) if (!pw2(p)) begin d[k] = c[p-1]; k++; end
    return d;
  endfunction

  function automatic logic [3:0] raw4(logic [7:0] c);
    return {c[6], c[5], c[4], c[2]};
  endfunction

  // position named by codeword bit index; overall parity bit counts as 0
  function automatic int posOf(int idx, int topIdx);
    return (idx == topIdx) ? 0 : idx + 1;
  endfunction

  task automatic runNarrow(logic [3:0] d, int f1, int f2);
    logic [7:0] good, mask;
    int nf, syn;
    good = enc4(d);
    mask = '0; nf = 0; syn = 0;
    if (f1 >= 0) begin mask[f1] = 1'b1; nf++; syn ^= posOf(f1, 7); end
    if (f2 >= 0) begin mask[f2] = 1'b1; nf++; syn ^= posOf(f2, 7); end
    @(posedge clk);
    nData = d; nCodeIn = good ^ mask;
    @(negedge clk);
    check("R1 R2 R3 narrow encode", nCodeOut, good);
    if (nf == 0) begin
      check("R4 narrow clean flags", {nClean, nCorr, nUnc}, 3'b100);
      check("R4 narrow clean data", nDataOut, d);
      check("R4 narrow clean syndrome", nSyn, 0);
    end else if (nf == 1) begin
      check(f1 == 7 ? "R6 narrow parity-only flags" : "R5 narrow single flags",
            {nClean, nCorr, nUnc}, 3'b010);
      check(f1 == 7 ? "R6 narrow parity-only data" : "R5 narrow single data", nDataOut, d);
      check("R5 R6 narrow syndrome", nSyn, syn);
    end else begin
      check("R7 narrow double flags", {nClean, nCorr, nUnc}, 3'b001);
      check("R7 narrow double raw data", nDataOut, raw4(good ^ mask));
      check("R7 narrow double syndrome", nSyn, syn);
    end
    check("R8 narrow onehot", $countones({nClean, nCorr, nUnc}), 1);
  endtask

  task automatic runWide(logic [10:0] d, int f1, int f2);
    logic [15:0] good, mask;
    int nf, syn;
    good = encW(d);
    mask = '0; nf = 0; syn = 0;
    if (f1 >= 0) begin mask[f1] = 1'b1; nf++; syn ^= posOf(f1, 15); end
    if (f2 >= 0) begin mask[f2] = 1'b1; nf++; syn ^= posOf(f2, 15); end
    @(posedge clk);
    wData = d; wCodeIn = good ^ mask;
    @(negedge clk);
    check("R9 R3 wide encode", wCodeOut, good);
    if (nf == 0) begin
      check("R9 R4 wide clean", {wClean, wCorr, wUnc, 5'b0, wDataOut}, {3'b100, 5'b0, d});
    end else if (nf == 1) begin
      check("R9 R5 R6 wide single", {wCorr, wUnc, wClean, 5'b0, wDataOut}, {3'b100, 5'b0, d});
      check("R9 R5 wide syndrome", wSyn, syn);
    end else begin
      check("R9 R7 wide double", {wUnc, wClean, wCorr, 5'b0, wDataOut},
            {3'b100, 5'b0, rawW(good ^ mask)});
      check("R9 R7 wide syndrome", wSyn, syn);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    nData = '0; nCodeIn = '0; wData = '0; wCodeIn = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // all-zero inputs: zero codeword, clean
    check("R4 reset-state code", nCodeOut, 8'h00);
    check("R4 reset-state flags", {nClean, nCorr, nUnc}, 3'b100);

    // worked example (R2, R5)
    @(posedge clk); nData = 4'b0110; nCodeIn = 8'h33;
    @(negedge clk);
    check("R2 worked codeword", nCodeOut, 8'h33);
    @(posedge clk); nCodeIn = 8'h33 ^ 8'h10;   // flip d2, position 5
    @(negedge clk);
    check("R5 worked d2 syndrome", nSyn, 5);
    check("R5 worked d2 data", nDataOut, 4'b0110);
    @(posedge clk); nCodeIn = 8'h33 ^ 8'h02;   // flip c2, position 2
    @(negedge clk);
    check("R5 worked c2 syndrome", nSyn, 2);
    check("R5 worked c2 data", nDataOut, 4'b0110);

    // exhaustive narrow: every data word, every single flip, every pair
    for (int d = 0; d < 16; d++) begin
      runNarrow(4'(d), -1, -1);
      for (int a = 0; a < 8; a++) begin
        runNarrow(4'(d), a, -1);
        for (int b = a + 1; b < 8; b++) runNarrow(4'(d), a, b);
      end
    end

    // wide: corners then random
    runWide(11'h000, -1, -1);
    runWide(11'h7FF, 15, -1);
    runWide(11'h7FF, 14, 15);
    for (int a = 0; a < 16; a++) runWide(11'h5A3, a, -1);
    for (int n = 0; n < 600; n++) begin
      logic [10:0] d;
      int a, b, kind;
      d = 11'($urandom);
      kind = $urandom_range(2, 0);
      a = $urandom_range(15, 0);
      b = $urandom_range(15, 0);
      if (b == a) b = (a + 1) % 16;
      if (kind == 0) runWide(d, -1, -1);
      else if (kind == 1) runWide(d, a, -1);
      else runWide(d, a, b);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule